// File: doc/BRIEF.md
# Memory Type Resolver

This block works out the effective caching type of one 4 KB physical page. The register bank that holds the range configuration decodes it and presents it as flat buses: a global enable, an enable for the low fixed region, a default type, 88 fixed-slot type bytes, and `NUM_VAR` variable base/mask pairs. The resolver accepts a page address through a valid strobe. It returns the resolved type with a one-cycle response strobe and a flag that reports when no variable range covered the page.

The resolver checks three cases in order. First, if the global enable is off, the answer depends only on whether the feature is present. Second, if the fixed region is enabled and the address is in the low megabyte, the matching fixed-slot byte is returned as is. Otherwise the resolver scans the variable pairs one per cycle and records the type of every active pair whose range overlaps the page. It then merges those types with a fixed precedence. A UC match stops the scan at once. The configuration buses must be held stable while `busy` is high and during the cycle in which `rsp_valid` is high.

Top module: `memtype_resolver`

## Requirements
- R1: With `global_en` low, the response type is UC (0) when `feature_present` is high and WB (6) when it is low, and `rsp_partial` is 0.
- R2: With `global_en` high, `fixed_en` high and the address below 0x100000, the response is the fixed-slot byte and the variable pairs have no effect on it.
- R3: The fixed slot is found by address. Below 0x80000 it is slot `addr[18:16]` (64 KB each). From 0x80000 to 0xBFFFF it is slot 8 + `addr[17:14]` (16 KB each). From 0xC0000 to 0xFFFFF it is slot 24 + `addr[17:12]` (4 KB each). Slot i is `fixed_types[8*i+7:8*i]`, and it is returned unchanged.
- R4: With `fixed_en` low, or with an address at or above 0x100000, the variable pairs decide the result.
- R5: A variable pair is active only while bit 11 of its mask is set. Its range starts at the base with bits 11:0 cleared. It ends just before (start OR NOT(mask with bits 11:0 cleared)) + 1.
- R6: An active pair matches when its range overlaps [page, page+4096). Its type is base bits 2:0, where legal codes are UC=0, WC=1, WT=4, WP=5 and WB=6.
- R7: The matched types are merged as follows. If all matched types are equal, that type is returned. If any matched type is UC, the result is UC. If the matched types are only WT and WB, the result is WT. Any other mix gives WB.
- R8: When the variable path finds no match, the response is `default_type` with `rsp_partial` = 1. In every other case `rsp_partial` is 0.
- R9: Counting the accepting clock edge as edge 1, a disabled or fixed response is visible after edge 2, and a full variable scan is visible after edge `NUM_VAR`+2. A UC match at pair j gives its response after edge j+3.
- R10: A request is accepted only while `busy` is low. `busy` is high from the edge after acceptance until the response edge. A `req_valid` raised while busy is ignored.
- R11: After reset, `busy`, `rsp_valid`, `rsp_type` and `rsp_partial` are 0. `rsp_valid` is high for a single cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Physical address of the page (bits 11:0 ignored) |
| feature_present | input | 1 | Range feature exists; selects the type used while disabled |
| global_en | input | 1 | Global enable of all ranges |
| fixed_en | input | 1 | Enable of the low fixed region |
| default_type | input | 8 | Type used when no range covers the page |
| fixed_types | input | 88*8 | Fixed-slot type bytes, slot i at bits 8i+7:8i |
| var_base | input | NUM_VAR*ADDR_W | Variable pair bases, pair k at bits ADDR_W*k+ADDR_W-1:ADDR_W*k |
| var_mask | input | NUM_VAR*ADDR_W | Variable pair masks, same packing; bit 11 is the active flag |
| busy | output | 1 | A lookup is in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_type | output | 8 | Resolved type |
| rsp_partial | output | 1 | Variable path found no covering range |

## Verification
There are three response times. Disabled and fixed lookups answer after edge 2. A full variable scan answers after edge `NUM_VAR`+2. A scan cut short by a UC match at pair j answers after edge j+3. The bench raises the request at a falling edge. It then counts rising edges and samples `rsp_valid` at each following falling edge. The count at which the strobe appears is checked against the latency its reference model predicts, in addition to the type and the partial flag. After each response the bench waits one more cycle before it changes the configuration, so the inputs stay stable for the whole lookup.

// File: rtl/memtype_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the memory type resolver.
// Assumes type codes fit in three bits (legal codes 0,1,4,5,6).
package memtype_pkg;

    localparam int FIXED_SLOTS = 88;
    localparam int TYPE_W      = 8;

    localparam logic [TYPE_W-1:0] MT_UC = 8'd0;
    localparam logic [TYPE_W-1:0] MT_WC = 8'd1;
    localparam logic [TYPE_W-1:0] MT_WT = 8'd4;
    localparam logic [TYPE_W-1:0] MT_WP = 8'd5;
    localparam logic [TYPE_W-1:0] MT_WB = 8'd6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } rs_state_t;

endpackage

// File: rtl/mt_fixed_decode.sv
`timescale 1ns/1ps
// Fixed region decoder: maps an address in the low megabyte to one of
// 88 slots (64 KB, 16 KB and 4 KB granularity) and returns its byte.
// Assumes ADDR_W > 20. Purely combinational.
module mt_fixed_decode
    import memtype_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          fixed_en,
    input  logic [FIXED_SLOTS*TYPE_W-1:0] fixed_types,
    output logic                          hit,
    output logic [TYPE_W-1:0]             slot_type
);

    logic [6:0] slot;
    logic       below_limit;
    logic       unused_low;

    assign unused_low = ^addr[11:0];

    // Region test and slot index selection by granularity
    always_comb begin
        below_limit = (addr[ADDR_W-1:20] == '0);
        if (!addr[19]) begin
            slot = {4'd0, addr[18:16]};
        end else if (!addr[18]) begin
            slot = 7'd8 + {3'd0, addr[17:14]};
        end else begin
            slot = 7'd24 + {1'b0, addr[17:12]};
        end
    end

    assign hit       = fixed_en && below_limit;
    assign slot_type = fixed_types[{slot, 3'b000} +: TYPE_W];

endmodule

// File: rtl/mt_var_match.sv
`timescale 1ns/1ps
// Variable pair matcher: decides whether one base/mask pair is active
// and overlaps the 4 KB page, and extracts the pair's type code.
// Range arithmetic is one bit wider than the address so the end of a
// range touching the top of the space does not wrap. Combinational.
module mt_var_match #(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-13:0] page,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  mask,
    output logic               hit,
    output logic [2:0]         kind
);

    localparam logic [ADDR_W:0] PAGE_BYTES = (ADDR_W+1)'(4096);
    localparam logic [ADDR_W:0] ONE        = (ADDR_W+1)'(1);

    logic [ADDR_W:0] r_start;
    logic [ADDR_W:0] r_span;
    logic [ADDR_W:0] r_end;
    logic [ADDR_W:0] p_start;
    logic [ADDR_W:0] p_end;
    logic            unused_bits;

    assign unused_bits = ^{base[11:3], mask[10:0]};

    // Range bounds of the pair and of the page
    always_comb begin
        r_start = {1'b0, base[ADDR_W-1:12], 12'h000};
        r_span  = {1'b0, ~mask[ADDR_W-1:12], 12'hFFF};
        r_end   = (r_start | r_span) + ONE;
        p_start = {1'b0, page, 12'h000};
        p_end   = p_start + PAGE_BYTES;
    end

    assign hit  = mask[11] && (r_start < p_end) && (r_end > p_start);
    assign kind = base[2:0];

endmodule

// File: rtl/mt_precedence.sv
`timescale 1ns/1ps
// Precedence merger: turns the set of matched type codes (one bit per
// code) into one type. Assumes at least one bit set; the caller picks
// the default type for an empty set.
module mt_precedence
    import memtype_pkg::*;
(
    input  logic [7:0]        seen,
    output logic [TYPE_W-1:0] merged
);

    localparam logic [7:0] WT_WB_SET = (8'b1 << MT_WT[2:0]) | (8'b1 << MT_WB[2:0]);

    // Apply UC-wins, single-type, WT/WB and fallback rules in that order
    always_comb begin
        merged = MT_WB;
        if (seen[MT_UC[2:0]]) begin
            merged = MT_UC;
        end else if ($countones(seen) == 1) begin
            for (int i = 0; i < 8; i++) begin
                if (seen[i]) merged = TYPE_W'(i);
            end
        end else if ((seen & ~WT_WB_SET) == 8'd0) begin
            merged = MT_WT;
        end
    end

endmodule

// File: rtl/memtype_resolver.sv
`timescale 1ns/1ps
// Memory type resolver top. Accepts one page lookup at a time. Resolves
// disabled and fixed cases directly, otherwise scans NUM_VAR variable
// pairs one per cycle (UC ends the scan) and merges matched types.
// Assumes the configuration inputs are stable while busy and in the
// response cycle.
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic                          feature_present,
    input  logic                          global_en,
    input  logic                          fixed_en,
    input  logic [TYPE_W-1:0]             default_type,
    input  logic [FIXED_SLOTS*TYPE_W-1:0] fixed_types,
    input  logic [NUM_VAR*ADDR_W-1:0]     var_base,
    input  logic [NUM_VAR*ADDR_W-1:0]     var_mask,
    output logic                          busy,
    output logic                          rsp_valid,
    output logic [TYPE_W-1:0]             rsp_type,
    output logic                          rsp_partial
);

    localparam int PG_W  = ADDR_W - 12;
    localparam int IDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VAR - 1);

    rs_state_t         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PG_W-1:0]   page_q;
    logic [7:0]        seen_q;
    logic [TYPE_W-1:0] fin_type_q;
    logic              direct_q;
    logic              rsp_valid_q;
    logic [TYPE_W-1:0] rsp_type_q;
    logic              rsp_partial_q;

    logic              fix_hit;
    logic [TYPE_W-1:0] fix_type;
    logic [ADDR_W-1:0] base_arr [NUM_VAR];
    logic [ADDR_W-1:0] mask_arr [NUM_VAR];
    logic              pair_hit;
    logic [2:0]        pair_kind;
    logic [TYPE_W-1:0] merged_type;

    // Split the flat pair buses into per-pair words
    for (genvar g = 0; g < NUM_VAR; g++) begin : g_unpack
        assign base_arr[g] = var_base[g*ADDR_W +: ADDR_W];
        assign mask_arr[g] = var_mask[g*ADDR_W +: ADDR_W];
    end

    mt_fixed_decode #(.ADDR_W(ADDR_W)) fixed_i (
        .addr        (req_addr),
        .fixed_en    (fixed_en),
        .fixed_types (fixed_types),
        .hit         (fix_hit),
        .slot_type   (fix_type)
    );

    mt_var_match #(.ADDR_W(ADDR_W)) match_i (
        .page (page_q),
        .base (base_arr[idx_q]),
        .mask (mask_arr[idx_q]),
        .hit  (pair_hit),
        .kind (pair_kind)
    );

    mt_precedence merge_i (
        .seen   (seen_q),
        .merged (merged_type)
    );

    // Lookup sequencer: accept, scan pairs, publish the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            idx_q         <= '0;
            page_q        <= '0;
            seen_q        <= '0;
            fin_type_q    <= '0;
            direct_q      <= 1'b0;
            rsp_valid_q   <= 1'b0;
            rsp_type_q    <= '0;
            rsp_partial_q <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        page_q <= req_addr[ADDR_W-1:12];
                        seen_q <= '0;
                        idx_q  <= '0;
                        if (!global_en) begin
                            fin_type_q <= feature_present ? MT_UC : MT_WB;
                            direct_q   <= 1'b1;
                            state_q    <= ST_DONE;
                        end else if (fix_hit) begin
                            fin_type_q <= fix_type;
                            direct_q   <= 1'b1;
                            state_q    <= ST_DONE;
                        end else begin
                            direct_q   <= 1'b0;
                            state_q    <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (pair_hit && ({5'd0, pair_kind} == MT_UC)) begin
                        fin_type_q <= MT_UC;
                        direct_q   <= 1'b1;
                        state_q    <= ST_DONE;
                    end else begin
                        if (pair_hit) seen_q <= seen_q | (8'b1 << pair_kind);
                        if (idx_q == LAST_IDX) state_q <= ST_DONE;
                        else                   idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    rsp_valid_q   <= 1'b1;
                    rsp_type_q    <= direct_q ? fin_type_q
                                   : ((seen_q == '0) ? default_type : merged_type);
                    rsp_partial_q <= !direct_q && (seen_q == '0);
                    state_q       <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign rsp_valid   = rsp_valid_q;
    assign rsp_type    = rsp_type_q;
    assign rsp_partial = rsp_partial_q;

    // R11: the response strobe never lasts two cycles
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: an idle request makes the block busy on the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R10: the block is free again in the cycle its result appears
    a_r10_idle_at_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    // R8: an uncovered page reports the default type
    a_r8_partial_gives_default: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_partial) |-> (rsp_type == default_type));

    // R1: disabled and absent feature resolves to WB without partial flag
    a_r1_absent_gives_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !global_en && !feature_present) |-> (rsp_type == MT_WB && !rsp_partial));

endmodule

// File: tb/memtype_resolver_tb_top.sv
`timescale 1ns/1ps
module memtype_resolver_tb_top;

    localparam int AW  = 36;
    localparam int NV  = 8;
    localparam int NFX = 88;
    localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic            present = 1'b1;
    logic            g_en = 1'b0;
    logic            f_en = 1'b0;
    logic [7:0]      dflt = 8'd0;
    logic [7:0]      fx [NFX];
    logic [AW-1:0]   vb [NV];
    logic [AW-1:0]   vm [NV];
    logic [NFX*8-1:0] fx_flat;
    logic [NV*AW-1:0] vb_flat;
    logic [NV*AW-1:0] vm_flat;
    logic            busy, rsp_valid, rsp_partial;
    logic [7:0]      rsp_type;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always_comb begin
        for (int i = 0; i < NFX; i++) fx_flat[i*8 +: 8] = fx[i];
        for (int k = 0; k < NV; k++) begin
            vb_flat[k*AW +: AW] = vb[k];
            vm_flat[k*AW +: AW] = vm[k];
        end
    end

    memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .feature_present(present), .global_en(g_en), .fixed_en(f_en),
        .default_type(dflt), .fixed_types(fx_flat), .var_base(vb_flat),
        .var_mask(vm_flat), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_type(rsp_type), .rsp_partial(rsp_partial)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] legal_type(input int n);
        case (n % 5)
            0: return 8'd0;
            1: return 8'd1;
            2: return 8'd4;
            3: return 8'd5;
            default: return 8'd6;
        endcase
    endfunction

    // Reference model built from the requirements
    function automatic void model(input logic [63:0] a, output logic [7:0] t,
                                  output logic p, output int lat);
        logic [7:0]  set8;
        logic [63:0] pg, s, e;
        int          slot, cnt;
        p = 1'b0;
        lat = 2;
        set8 = 8'd0;
        if (!g_en) begin
            t = present ? 8'd0 : 8'd6;
            return;
        end
        if (f_en && a < 64'h100000) begin
            if (a < 64'h80000)      slot = int'(a >> 16);
            else if (a < 64'hC0000) slot = 8 + int'((a - 64'h80000) >> 14);
            else                    slot = 24 + int'((a - 64'hC0000) >> 12);
            t = fx[slot];
            return;
        end
        lat = NV + 2;
        pg = a & AMASK & ~64'hFFF;
        for (int j = 0; j < NV; j++) begin
            s = {28'd0, vb[j]} & ~64'hFFF;
            e = (s | (~({28'd0, vm[j]} & ~64'hFFF) & AMASK)) + 64'd1;
            if (vm[j][11] && s < pg + 64'd4096 && e > pg) begin
                if (vb[j][2:0] == 3'd0) begin
                    t = 8'd0;
                    lat = j + 3;
                    return;
                end
                set8[vb[j][2:0]] = 1'b1;
            end
        end
        cnt = $countones(set8);
        if (cnt == 0) begin
            t = dflt;
            p = 1'b1;
        end else if (cnt == 1) begin
            t = 8'd0;
            for (int i = 0; i < 8; i++) if (set8[i]) t = 8'(i);
        end else if ((set8 & ~8'h50) == 8'd0) begin
            t = 8'd4;
        end else begin
            t = 8'd6;
        end
    endfunction

    task automatic run(input logic [63:0] a, input string req);
        logic [7:0] et;
        logic       ep;
        int         el, lat;
        bit         got;
        model(a, et, ep, el);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a[AW-1:0];
        lat = 0;
        got = 1'b0;
        while (!got && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (rsp_valid) got = 1'b1;
        end
        chk(req, "latency (R9)", lat, el);
        chk(req, "type", rsp_type, et);
        chk(req, "partial (R8)", rsp_partial, ep);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_vars();
        for (int k = 0; k < NV; k++) begin
            vb[k] = '0;
            vm[k] = '0;
        end
    endtask

    // Pair k covers 2^lg pages from base b with type t
    task automatic set_var(input int k, input logic [63:0] b, input int lg,
                           input logic [7:0] t, input bit act);
        logic [63:0] m;
        m = AMASK & ~((64'd1 << (12 + lg)) - 64'd1);
        vb[k] = AW'((b & ~64'hFFF) | {56'd0, t});
        vm[k] = AW'(m | (act ? 64'h800 : 64'h0));
    endtask

    task automatic random_cfg();
        int lg, bp;
        g_en = ($urandom % 8) != 0;
        present = $urandom % 2;
        f_en = $urandom % 2;
        dflt = legal_type($urandom);
        for (int i = 0; i < NFX; i++) fx[i] = legal_type($urandom);
        for (int k = 0; k < NV; k++) begin
            lg = $urandom % 6;
            bp = ($urandom % 4096) & ~((1 << lg) - 1);
            set_var(k, 64'(bp) << 12, lg, legal_type($urandom), ($urandom % 4) != 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        bit seen_rsp;
        void'($urandom(32'd4242));
        for (int i = 0; i < NFX; i++) fx[i] = 8'(i);
        clear_vars();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "reset busy", busy, 0);
        chk("R11", "reset rsp_valid", rsp_valid, 0);
        chk("R11", "reset rsp_type", rsp_type, 0);
        chk("R11", "reset rsp_partial", rsp_partial, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: disabled behaviour
        g_en = 1'b0; present = 1'b1; run(64'h200000, "R1");
        present = 1'b0; run(64'h5000, "R1");
        present = 1'b1;

        // R2, R3: fixed slots at every region boundary, with a UC pair overlapping
        g_en = 1'b1; f_en = 1'b1; dflt = 8'd1;
        set_var(0, 64'h0, 8, 8'd0, 1'b1);
        run(64'h00000, "R3"); run(64'h7F000, "R3"); run(64'h80000, "R3");
        run(64'hBF000, "R3"); run(64'hC0000, "R3"); run(64'hFF000, "R3");
        run(64'h43000, "R2"); run(64'h9D000, "R3");

        // R4: fixed disabled, and the first address above the region
        f_en = 1'b0; run(64'h43000, "R4");
        f_en = 1'b1; clear_vars();
        set_var(2, 64'h100000, 0, 8'd5, 1'b1);
        run(64'h100000, "R4");

        // R7: WT and WB give WT; WC with WB gives WB; equal types stay
        clear_vars();
        set_var(1, 64'h200000, 9, 8'd6, 1'b1);
        set_var(5, 64'h200000, 0, 8'd4, 1'b1);
        set_var(3, 64'h200000, 1, 8'd6, 1'b1);
        run(64'h200000, "R7");
        set_var(5, 64'h200000, 0, 8'd1, 1'b1);
        run(64'h200000, "R7");
        clear_vars();
        set_var(0, 64'h400000, 2, 8'd5, 1'b1);
        set_var(4, 64'h400000, 4, 8'd5, 1'b1);
        run(64'h401000, "R7");
        // R7, R9: UC at pair 6 wins and ends the scan
        set_var(1, 64'h400000, 3, 8'd6, 1'b1);
        set_var(6, 64'h400000, 0, 8'd0, 1'b1);
        run(64'h400000, "R7");

        // R5: a UC pair with bit 11 clear is ignored
        clear_vars();
        set_var(2, 64'h600000, 3, 8'd0, 1'b0);
        set_var(7, 64'h600000, 3, 8'd6, 1'b1);
        run(64'h601000, "R5");

        // R6, R8: range edges; outside gives the default with partial set
        clear_vars();
        set_var(0, 64'h300000, 2, 8'd4, 1'b1);
        run(64'h303000, "R6"); run(64'h304000, "R8"); run(64'h2FF000, "R8");
        run(64'h300000, "R6");

        // R10: a request raised while busy is ignored
        clear_vars();
        set_var(1, 64'h800000, 0, 8'd6, 1'b1);
        f_en = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(64'h800000);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "busy after accept", busy, 1);
        cyc = 1;
        @(posedge clk); @(negedge clk);
        cyc++;
        req_valid = 1'b1; req_addr = AW'(64'h900000);
        @(posedge clk); @(negedge clk);
        cyc++;
        req_valid = 1'b0;
        while (!rsp_valid && cyc < 100) begin
            @(posedge clk); @(negedge clk);
            cyc++;
        end
        chk("R10", "latency with ignored request", cyc, NV + 2);
        chk("R10", "type of first request", rsp_type, 6);
        seen_rsp = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); @(negedge clk);
            if (rsp_valid || busy) seen_rsp = 1'b1;
        end
        chk("R10", "no response to ignored request", seen_rsp, 0);
        chk("R11", "strobe single cycle", rsp_valid, 0);

        // Random configurations and addresses
        for (int n = 0; n < 40; n++) begin
            random_cfg();
            for (int r = 0; r < 8; r++) begin
                if ($urandom % 2) run(64'($urandom % 256) << 12, "R2/R6");
                else              run(64'($urandom % 4096) << 12, "R6/R7");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule